// File: doc/BRIEF.md
# String Block Move Engine

The engine copies a run of elements from one memory region to another over a single-port request/ready memory interface. A caller supplies a base for each side, a starting index for each side, an element size (byte, word or doubleword), an address width mode (16 or 32 bits), a direction flag and an optional repeat mode with a count. The caller picks the source base. This lets a different source region be used in place of the default. The destination base is always the fixed destination region supplied on its own port.

Each element takes one read at the source address, then one write of the same data at the destination address. After the write, both indices move by the element size, either up or down. In 16-bit address mode, only the low halves of the indices and the count take part and wrap. Their upper halves keep their values. When the run ends, the final indices and count stay on the outputs and a one-cycle done pulse is raised.

Top module: `str_move_engine`

## Requirements
- R1: A start_i pulse while idle latches all operands and raises busy_o. busy_o stays high until done_o is raised. done_o is high for exactly one cycle, after which the engine is idle again. mem_req_o is only ever high while busy_o is high.
- R2: Each element issues a read (mem_we_o=0) at src_base + effective source index. The next request is a write (mem_we_o=1) at dst_base + effective destination index. Each request holds its address and direction until mem_ready_i is high.
- R3: After each element's write is accepted, both indices change by 1, 2 or 4 for size codes 0 (byte), 1 (word) and 2 (doubleword).
- R4: With dir_down_i=0 both indices increase. With dir_down_i=1 both decrease.
- R5: With addr32_i=0 only bits 15:0 of the indices form the address offset and are updated, wrapping modulo 2^16. Bits 31:16 are preserved. With addr32_i=1 all 32 bits are used and updated.
- R6: With rep_i=0 exactly one element is moved and cnt_o keeps its starting value.
- R7: With rep_i=1 the count decrements once per element and the run stops when it reaches zero. The count is bits 15:0 with addr32_i=0 (bits 31:16 preserved) and all 32 bits with addr32_i=1.
- R8: With rep_i=1 and a zero effective starting count, no memory request is made. done_o follows, and the indices and count are unchanged.
- R9: mem_size_o carries the element size code. The write data equals the data returned by the element's read; memory uses the low 1, 2 or 4 bytes, little-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken while idle |
| size_i | input | 2 | Element size code: 0 byte, 1 word, 2 doubleword |
| addr32_i | input | 1 | 1: 32-bit indices/count, 0: 16-bit |
| dir_down_i | input | 1 | 1: indices decrease, 0: increase |
| rep_i | input | 1 | Repeat mode enable |
| src_base_i | input | 32 | Source region base |
| dst_base_i | input | 32 | Destination region base |
| src_idx_i | input | 32 | Starting source index |
| dst_idx_i | input | 32 | Starting destination index |
| cnt_i | input | 32 | Starting element count |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1: write, 0: read |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted this cycle (read data valid) |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_idx_o | output | 32 | Current/final source index |
| dst_idx_o | output | 32 | Current/final destination index |
| cnt_o | output | 32 | Current/final count |

## Verification
The bench targets the 16-bit wrap: an index of 0001h stepping down, and FFFEh stepping up by two. A design that carried into bit 16 or cleared the upper half would show wrong final indices and write to the wrong bytes. It runs a count whose low half is zero but whose upper half is not, in 16-bit mode. A design that checked all 32 bits would copy 65536 elements instead of none. It also checks that the count is left untouched when repeat is off, and that the run ends correctly when memory stalls every other cycle. A design that dropped or repeated a request would leave wrong destination bytes or a wrong count of writes.

// File: rtl/strmv_pkg.sv
package strmv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } strmv_state_e;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;
endpackage

// File: rtl/strmv_index_step.sv
module strmv_index_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx_i,
  input  logic [1:0]    size_i,
  input  logic          a32_i,
  input  logic          down_i,
  output logic [AW-1:0] eff_o,
  output logic [AW-1:0] nxt_o
);
  localparam int HW = AW / 2;

  logic [AW-1:0] delta;
  logic [AW-1:0] full_nxt;
  logic [HW-1:0] half_nxt;

  always_comb begin
    unique case (size_i)
      strmv_pkg::SZ_BYTE: delta = AW'(1);
      strmv_pkg::SZ_WORD: delta = AW'(2);
      default:            delta = AW'(4);
    endcase
  end

  assign full_nxt = down_i ? (idx_i - delta) : (idx_i + delta);
  assign half_nxt = down_i ? (idx_i[HW-1:0] - delta[HW-1:0])
                           : (idx_i[HW-1:0] + delta[HW-1:0]);

  assign eff_o = a32_i ? idx_i : {{(AW-HW){1'b0}}, idx_i[HW-1:0]};
  assign nxt_o = a32_i ? full_nxt : {idx_i[AW-1:HW], half_nxt};
endmodule

// File: rtl/strmv_count.sv
module strmv_count #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cnt_i,
  input  logic          a32_i,
  output logic [AW-1:0] dec_o,
  output logic          zero_o,
  output logic          one_o
);
  localparam int HW = AW / 2;

  logic [HW-1:0] half_dec;

  assign half_dec = cnt_i[HW-1:0] - HW'(1);
  assign dec_o    = a32_i ? (cnt_i - AW'(1)) : {cnt_i[AW-1:HW], half_dec};
  assign zero_o   = a32_i ? (cnt_i == '0) : (cnt_i[HW-1:0] == '0);
  assign one_o    = a32_i ? (cnt_i == AW'(1)) : (cnt_i[HW-1:0] == HW'(1));
endmodule

// File: rtl/strmv_seq.sv
module strmv_seq
  import strmv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic skip_i,
  input  logic ready_i,
  input  logic last_i,
  output logic load_o,
  output logic cap_o,
  output logic adv_o,
  output logic req_o,
  output logic we_o,
  output logic busy_o,
  output logic done_o
);
  strmv_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = skip_i ? ST_DONE : ST_RD;
      ST_RD:   if (ready_i) st_d = ST_WR;
      ST_WR:   if (ready_i) st_d = last_i ? ST_DONE : ST_RD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign cap_o  = (st_q == ST_RD) && ready_i;
  assign adv_o  = (st_q == ST_WR) && ready_i;
  assign req_o  = (st_q == ST_RD) || (st_q == ST_WR);
  assign we_o   = (st_q == ST_WR);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/str_move_engine.sv
module str_move_engine
  import strmv_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    size_i,
  input  logic          addr32_i,
  input  logic          dir_down_i,
  input  logic          rep_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [AW-1:0] src_idx_i,
  input  logic [AW-1:0] dst_idx_i,
  input  logic [AW-1:0] cnt_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] src_idx_o,
  output logic [AW-1:0] dst_idx_o,
  output logic [AW-1:0] cnt_o
);
  localparam int NIDX = 2;

  logic [1:0]    size_q;
  logic          a32_q, dn_q, rep_q;
  logic [AW-1:0] sbase_q, dbase_q, cnt_q;
  logic [AW-1:0] idx_q [NIDX];
  logic [AW-1:0] idx_eff [NIDX];
  logic [AW-1:0] idx_nxt [NIDX];
  logic [DW-1:0] buf_q;

  logic          load, cap, adv, last, skip;
  logic [AW-1:0] cnt_dec, cnt_in_dec;
  logic          cnt_zero, cnt_one, cnt_in_zero, cnt_in_one;

  // index 0 = source, 1 = destination
  for (genvar g = 0; g < NIDX; g++) begin : g_idx
    strmv_index_step #(.AW(AW)) u_step (
      .idx_i  (idx_q[g]),
      .size_i (size_q),
      .a32_i  (a32_q),
      .down_i (dn_q),
      .eff_o  (idx_eff[g]),
      .nxt_o  (idx_nxt[g])
    );
  end

  strmv_count #(.AW(AW)) u_cnt_run (
    .cnt_i  (cnt_q),
    .a32_i  (a32_q),
    .dec_o  (cnt_dec),
    .zero_o (cnt_zero),
    .one_o  (cnt_one)
  );

  strmv_count #(.AW(AW)) u_cnt_start (
    .cnt_i  (cnt_i),
    .a32_i  (addr32_i),
    .dec_o  (cnt_in_dec),
    .zero_o (cnt_in_zero),
    .one_o  (cnt_in_one)
  );

  assign skip = rep_i && cnt_in_zero;
  assign last = !rep_q || cnt_one || cnt_zero;

  strmv_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .skip_i  (skip),
    .ready_i (mem_ready_i),
    .last_i  (last),
    .load_o  (load),
    .cap_o   (cap),
    .adv_o   (adv),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= SZ_BYTE;
      a32_q   <= 1'b0;
      dn_q    <= 1'b0;
      rep_q   <= 1'b0;
      sbase_q <= '0;
      dbase_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '{default: '0};
      buf_q   <= '0;
    end else if (load) begin
      size_q   <= size_i;
      a32_q    <= addr32_i;
      dn_q     <= dir_down_i;
      rep_q    <= rep_i;
      sbase_q  <= src_base_i;
      dbase_q  <= dst_base_i;
      cnt_q    <= cnt_i;
      idx_q[0] <= src_idx_i;
      idx_q[1] <= dst_idx_i;
    end else begin
      if (cap) buf_q <= mem_rdata_i;
      if (adv) begin
        idx_q[0] <= idx_nxt[0];
        idx_q[1] <= idx_nxt[1];
        if (rep_q) cnt_q <= cnt_dec;
      end
    end
  end

  assign mem_addr_o  = mem_we_o ? (dbase_q + idx_eff[1]) : (sbase_q + idx_eff[0]);
  assign mem_size_o  = size_q;
  assign mem_wdata_o = buf_q;
  assign src_idx_o   = idx_q[0];
  assign dst_idx_o   = idx_q[1];
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/strmv_chk.sv
module strmv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ready_i,
  input logic [31:0] mem_rdata_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] src_idx_o,
  input logic [31:0] cnt_o,
  input logic [1:0]  size_q,
  input logic        a32_q,
  input logic        dn_q,
  input logic        rep_q
);
  logic wr_hs, rd_hs;
  assign wr_hs = mem_req_o && mem_we_o && mem_ready_i;
  assign rd_hs = mem_req_o && !mem_we_o && mem_ready_i;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R2
  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hs |=> (mem_req_o && mem_we_o)); // R2
  AST_STEP_WORD_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hs && a32_q && !dn_q && size_q == 2'd1) |=> (src_idx_o == $past(src_idx_o) + 32'd2)); // R3
  AST_STEP_BYTE_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hs && a32_q && dn_q && size_q == 2'd0) |=> (src_idx_o == $past(src_idx_o) - 32'd1)); // R4
  AST_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hs && !a32_q) |=> (src_idx_o[31:16] == $past(src_idx_o[31:16]))); // R5
  AST_SINGLE_NOREP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hs && !rep_q) |=> (done_o && $stable(cnt_o))); // R6
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hs && rep_q && a32_q) |=> (cnt_o == $past(cnt_o) - 32'd1)); // R7
  AST_WDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hs |=> (mem_wdata_o == $past(mem_rdata_i))); // R9
endmodule

bind str_move_engine strmv_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .mem_rdata_i (mem_rdata_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .src_idx_o   (src_idx_o),
  .cnt_o       (cnt_o),
  .size_q      (size_q),
  .a32_q       (a32_q),
  .dn_q        (dn_q),
  .rep_q       (rep_q)
);

// File: tb/sim_str_move_engine.sv
module sim_str_move_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic        addr32_i = 1'b0, dir_down_i = 1'b0, rep_i = 1'b0;
  logic [31:0] src_base_i = '0, dst_base_i = '0, src_idx_i = '0, dst_idx_i = '0, cnt_i = '0;
  logic        mem_req_o, mem_we_o, mem_ready_i, busy_o, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, src_idx_o, dst_idx_o, cnt_o;
  logic [1:0]  mem_size_o;

  int total = 0, bad = 0, n_wr = 0, n_rd = 0;
  logic stall_en = 1'b0, rdy_ph = 1'b0;
  logic [7:0] mem [4096];

  always #5 clk = ~clk;

  str_move_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .size_i(size_i),
    .addr32_i(addr32_i), .dir_down_i(dir_down_i), .rep_i(rep_i),
    .src_base_i(src_base_i), .dst_base_i(dst_base_i), .src_idx_i(src_idx_i),
    .dst_idx_i(dst_idx_i), .cnt_i(cnt_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o), .cnt_o(cnt_o)
  );

  function automatic logic [7:0] pat(input logic [11:0] a);
    return 8'(a * 13 + 7) ^ 8'(a >> 8);
  endfunction

  assign mem_ready_i = mem_req_o && (!stall_en || rdy_ph);
  assign mem_rdata_i = {mem[12'(mem_addr_o + 3)], mem[12'(mem_addr_o + 2)],
                        mem[12'(mem_addr_o + 1)], mem[12'(mem_addr_o)]};

  always @(negedge clk) rdy_ph <= ~rdy_ph;

  always @(posedge clk) begin
    if (mem_req_o && mem_ready_i) begin
      if (mem_we_o) begin
        n_wr <= n_wr + 1;
        for (int b = 0; b < 4; b++)
          if (b < (1 << mem_size_o)) mem[12'(mem_addr_o + 32'(b))] <= mem_wdata_o[8*b +: 8];
      end else begin
        n_rd <= n_rd + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic        a32, dn, rep;
    logic [31:0] sb, db, si, di, cnt, esi, edi, ecnt;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b1, 1'b0, 1'b0, 32'h100, 32'h800, 32'h10, 32'h20, 32'd5,
      32'h11, 32'h21, 32'd5},
    '{2'd1, 1'b1, 1'b0, 1'b1, 32'h100, 32'h800, 32'h10, 32'h40, 32'd4,
      32'h18, 32'h48, 32'd0},
    '{2'd2, 1'b1, 1'b1, 1'b1, 32'h100, 32'h800, 32'h40, 32'h80, 32'd3,
      32'h34, 32'h74, 32'd0},
    '{2'd0, 1'b0, 1'b1, 1'b1, 32'h200, 32'h900, 32'hABCD_0001, 32'h5555_0000, 32'h1234_0002,
      32'hABCD_FFFF, 32'h5555_FFFE, 32'h1234_0000},
    '{2'd1, 1'b1, 1'b0, 1'b1, 32'h100, 32'h800, 32'h10, 32'h40, 32'd0,
      32'h10, 32'h40, 32'd0},
    '{2'd0, 1'b0, 1'b0, 1'b1, 32'h100, 32'h800, 32'h50, 32'h60, 32'h0001_0000,
      32'h50, 32'h60, 32'h0001_0000},
    '{2'd1, 1'b0, 1'b0, 1'b1, 32'h300, 32'hA00, 32'h0000_FFFE, 32'h10, 32'd2,
      32'h0000_0002, 32'h14, 32'd0},
    '{2'd2, 1'b1, 1'b0, 1'b0, 32'h100, 32'h800, 32'h8, 32'h30, 32'd0,
      32'hC, 32'h34, 32'd0}
  };

  task automatic run_vec(input vec_t v, input int id);
    int n_el, wait_cyc;
    logic [31:0] s, d;
    int bytes;
    for (int i = 0; i < 4096; i++) mem[i] = pat(12'(i));
    @(negedge clk);
    n_wr = 0; n_rd = 0;
    size_i = v.sz; addr32_i = v.a32; dir_down_i = v.dn; rep_i = v.rep;
    src_base_i = v.sb; dst_base_i = v.db; src_idx_i = v.si; dst_idx_i = v.di; cnt_i = v.cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk($sformatf("R1 busy v%0d", id), 32'(busy_o), 32'd1);
    wait_cyc = 0;
    while (!done_o && wait_cyc < 400) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk($sformatf("R1 done v%0d", id), 32'(done_o), 32'd1);
    chk($sformatf("R3 R4 R5 src index v%0d", id), src_idx_o, v.esi);
    chk($sformatf("R3 R4 R5 dst index v%0d", id), dst_idx_o, v.edi);
    chk($sformatf("R6 R7 count v%0d", id), cnt_o, v.ecnt);
    bytes = 1 << v.sz;
    if (!v.rep) n_el = 1;
    else n_el = v.a32 ? int'(v.cnt) : int'(v.cnt[15:0]);
    chk($sformatf("R6 R7 R8 writes v%0d", id), 32'(n_wr), 32'(n_el));
    chk($sformatf("R2 R8 reads v%0d", id), 32'(n_rd), 32'(n_el));
    s = v.si; d = v.di;
    for (int k = 0; k < n_el; k++) begin
      for (int b = 0; b < bytes; b++)
        chk($sformatf("R2 R9 data v%0d e%0d b%0d", id, k, b),
            32'(mem[12'(v.db + (v.a32 ? d : {16'h0, d[15:0]}) + 32'(b))]),
            32'(pat(12'(v.sb + (v.a32 ? s : {16'h0, s[15:0]}) + 32'(b)))));
      s = v.dn ? s - 32'(bytes) : s + 32'(bytes);
      d = v.dn ? d - 32'(bytes) : d + 32'(bytes);
    end
    @(negedge clk);
    chk($sformatf("R1 pulse end v%0d", id), {30'h0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 32'(busy_o), 32'd0);
    chk("R1 reset done", 32'(done_o), 32'd0);
    chk("R2 reset req", 32'(mem_req_o), 32'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) run_vec(VECS[i], i);
    // stalled memory: every other cycle not ready
    stall_en = 1'b1;
    run_vec(VECS[1], 11);
    run_vec(VECS[3], 13);
    stall_en = 1'b0;
    // size code visible on the bus during a word run (R9)
    @(negedge clk);
    size_i = 2'd1; addr32_i = 1'b1; rep_i = 1'b0; dir_down_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 size code", 32'(mem_size_o), 32'd1);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule